// File: doc/BRIEF.md
# Eight-Port Serial Register Front End

This block sits between a host register bus and eight serial-port register files that share one 64-byte address window. Each port owns eight consecutive byte offsets, so address bits 5..3 pick the port (port n at offsets 8*(n-1) to 8*(n-1)+7) and bits 2..0 pick the register inside it. Offsets 0 through 6 of a port are forwarded to that port with a one-hot enable, and its read data comes back unchanged.

Offset 7 of every port is taken over by the block. It is no longer that port's scratch byte. Instead it reaches one of two registers shared by all ports. A two-state selector machine decides which one. It has the states `SEL_STATUS` and `SEL_OPTIONS`. The only transition happens on a write to offset 3, the line control register, of any port. If bit 7 of that write is 1, the machine goes to `SEL_OPTIONS`. If it is 0, the machine goes to `SEL_STATUS`. Every other cycle keeps the current state.

The status register shows which ports have an interrupt pending. The block also drives a single level-sensitive interrupt line that is the OR of the eight port requests. The options register holds two identification bits and a two-bit clock-rate multiplier. The multiplier is driven to every port's baud generator. The identification bits do not read back as written: they read back as logic functions of the written bits, so software can detect the block.

Top module: `sio_hub`

## Requirements
- R1: After reset, `irq_out` is 0, `clk_mult` is 0, `rd_valid` is 0, no port enable is active, and the selector is in `SEL_STATUS`, so offset 7 reads the status register.
- R2: An access to offset o (0..6) of port n drives `port_sel` with only bit n-1 set. It drives `port_addr` = o, passes `acc_write` to `port_wr` and `acc_wdata` to `port_wdata`. A read returns byte lane n-1 of `port_rdata` (bits 8*(n-1)+7..8*(n-1)).
- R3: An access to offset 7 of any port activates no port enable and asserts no `port_wr`.
- R4: A write to offset 3 of any port moves the selector to `SEL_OPTIONS` when data bit 7 is 1, and to `SEL_STATUS` when it is 0. The selector then holds until the next such write.
- R5: In `SEL_STATUS`, a read of offset 7 of any port returns the status byte. Bit k of that byte equals `port_irq[k]` in the read cycle, with port 1 at bit 0 and port 8 at bit 7.
- R6: `irq_out` equals the OR of all `port_irq` bits, registered one clock later.
- R7: In `SEL_OPTIONS`, a read of offset 7 returns bits 5..2 as 0 whatever was written there, and bits 1..0 as the last written multiplier.
- R8: The ID field is bits 7..6 of an options write. On read, bit 7 is the AND of the two written ID bits and bit 6 is their XOR. Written {b7,b6} of 00, 01, 10 and 11 read back as 00, 01, 01 and 10.
- R9: An options write (offset 7, `SEL_OPTIONS`) loads `clk_mult` from data bits 1..0 on that clock edge. `clk_mult` does not change on any other access.
- R10: A write to offset 7 in `SEL_STATUS` is ignored. It changes neither the options register, nor `clk_mult`, nor the selector.
- R11: `rd_valid` rises for exactly the one cycle after a read strobe and carries the read result in `rd_data`. It stays 0 after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Window byte address: port in 5..3, register offset in 2..0 |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| port_sel | output | 8 | One-hot port enable for offsets 0..6 |
| port_wr | output | 1 | Write qualifier for the enabled port |
| port_addr | output | 3 | Register offset forwarded to the ports |
| port_wdata | output | 8 | Write data forwarded to the ports |
| port_rdata | input | 64 | Read data of all ports, lane k for port k+1 |
| port_irq | input | 8 | Per-port interrupt request, bit k for port k+1 |
| irq_out | output | 1 | Shared level-sensitive interrupt |
| clk_mult | output | 2 | Clock-rate multiplier to all baud generators |

## Verification
The hardest situation to create from the ports is a selector change made through one port and then seen through another. The bench writes the line control register of port 3 and reads offset 7 through port 8. It then writes it through port 8 and reads through port 2. This proves the selector is shared and not per-port. The case where a write is ignored can only be seen indirectly. After writing offset 7 in `SEL_STATUS`, the bench checks `clk_mult` at once. It then switches to `SEL_OPTIONS` and reads the options register back, confirming the earlier value survived.

// File: rtl/sio_hub_pkg.sv
package sio_hub_pkg;
    typedef enum logic [0:0] {
        SEL_STATUS  = 1'b0,
        SEL_OPTIONS = 1'b1
    } sel_state_e;

    localparam int LCR_OFFSET     = 3;
    localparam int SPECIAL_OFFSET = 7;
    localparam int DLAB_BIT       = 7;
    localparam int OPT_W          = 8;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
    parameter int NUM_PORTS = 8,
    parameter int OFF_W     = 3,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                 acc_valid,
    input  logic [PORT_W-1:0]    port_idx,
    input  logic [OFF_W-1:0]     offset,
    output logic [NUM_PORTS-1:0] port_sel,
    output logic                 is_special
);
    import sio_hub_pkg::*;

    assign is_special = (offset == OFF_W'(SPECIAL_OFFSET));

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
        assign port_sel[g] = acc_valid && !is_special && (port_idx == PORT_W'(g));
    end
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_irq,
    output logic [NUM_PORTS-1:0] status,
    output logic                 irq_out
);
    assign status = port_irq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |port_irq;
        end
    end
endmodule

// File: rtl/sio_opt_reg.sv
module sio_opt_reg
    import sio_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OPT_W-1:0] wdata,
    output logic [OPT_W-1:0] rd_view,
    output logic [1:0]       clk_mult
);
    logic [1:0] id_q;
    logic [1:0] mult_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= 2'b00;
            mult_q <= 2'b00;
        end else if (wr_en) begin
            id_q   <= wdata[7:6];
            mult_q <= wdata[1:0];
        end
    end

    assign rd_view  = {id_q[1] & id_q[0], id_q[1] ^ id_q[0], 4'b0000, mult_q};
    assign clk_mult = mult_q;
endmodule

// File: rtl/sio_hub.sv
module sio_hub
    import sio_hub_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int REG_SPAN  = 8,
    parameter int DATA_W    = 8,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int OFF_W    = $clog2(REG_SPAN),
    localparam int ADDR_W   = PORT_W + OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [DATA_W-1:0]           acc_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_PORTS-1:0]        port_sel,
    output logic                        port_wr,
    output logic [OFF_W-1:0]            port_addr,
    output logic [DATA_W-1:0]           port_wdata,
    input  logic [NUM_PORTS*DATA_W-1:0] port_rdata,
    input  logic [NUM_PORTS-1:0]        port_irq,
    output logic                        irq_out,
    output logic [1:0]                  clk_mult
);
    logic [PORT_W-1:0]    port_idx;
    logic [OFF_W-1:0]     offset;
    logic                 is_special;
    logic                 lcr_write;
    logic                 opt_wr;
    logic [NUM_PORTS-1:0] status;
    logic [OPT_W-1:0]     opt_view;
    logic [DATA_W-1:0]    special_rd;
    logic [DATA_W-1:0]    lane_rd;
    sel_state_e           sel_q, sel_d;

    assign port_idx = acc_addr[ADDR_W-1:OFF_W];
    assign offset   = acc_addr[OFF_W-1:0];

    sio_addr_decode #(.NUM_PORTS(NUM_PORTS), .OFF_W(OFF_W)) u_decode (
        .acc_valid (acc_valid),
        .port_idx  (port_idx),
        .offset    (offset),
        .port_sel  (port_sel),
        .is_special(is_special)
    );

    sio_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_irq(port_irq),
        .status  (status),
        .irq_out (irq_out)
    );

    sio_opt_reg u_opt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (opt_wr),
        .wdata   (OPT_W'(acc_wdata)),
        .rd_view (opt_view),
        .clk_mult(clk_mult)
    );

    assign port_wr    = acc_valid && acc_write && !is_special;
    assign port_addr  = offset;
    assign port_wdata = acc_wdata;
    assign lcr_write  = port_wr && (offset == OFF_W'(LCR_OFFSET));
    assign lane_rd    = port_rdata[port_idx*DATA_W +: DATA_W];

    // Selector state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_STATUS;
        end else begin
            sel_q <= sel_d;
        end
    end

    // Selector transitions: only a line-control write moves it
    always_comb begin
        sel_d = sel_q;
        if (lcr_write) begin
            sel_d = acc_wdata[DLAB_BIT] ? SEL_OPTIONS : SEL_STATUS;
        end
    end

    // Per-state outputs: special read view and options write enable
    always_comb begin
        special_rd = '0;
        opt_wr     = 1'b0;
        unique case (sel_q)
            SEL_STATUS: begin
                special_rd = DATA_W'(status);
            end
            SEL_OPTIONS: begin
                special_rd = DATA_W'(opt_view);
                opt_wr     = acc_valid && acc_write && is_special;
            end
            default: begin
                special_rd = '0;
            end
        endcase
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) begin
                rd_data <= is_special ? special_rd : lane_rd;
            end
        end
    end
endmodule

// File: rtl/sio_hub_chk.sv
module sio_hub_chk #(
    parameter int NUM_PORTS = 8,
    parameter int OFF_W     = 3,
    parameter int ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic                 rd_valid,
    input logic [NUM_PORTS-1:0] port_sel,
    input logic                 port_wr,
    input logic [NUM_PORTS-1:0] port_irq,
    input logic                 irq_out,
    input logic [1:0]           clk_mult
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel)); // R2

    AST_SPECIAL_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (&acc_addr[OFF_W-1:0])) |-> (port_sel == '0 && !port_wr)); // R3

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_irq) |=> irq_out); // R6

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|port_irq) |=> !irq_out); // R6

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid); // R11

    AST_NO_SPURIOUS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid); // R11

    AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && (&acc_addr[OFF_W-1:0])) |=> $stable(clk_mult)); // R9
endmodule

bind sio_hub sio_hub_chk #(.NUM_PORTS(NUM_PORTS), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .rd_valid (rd_valid),
    .port_sel (port_sel),
    .port_wr  (port_wr),
    .port_irq (port_irq),
    .irq_out  (irq_out),
    .clk_mult (clk_mult)
);

// File: tb/sio_hub_tb_top.sv
module sio_hub_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  port_sel;
    logic        port_wr;
    logic [2:0]  port_addr;
    logic [7:0]  port_wdata;
    logic [63:0] port_rdata;
    logic [7:0]  port_irq = '0;
    logic        irq_out;
    logic [1:0]  clk_mult;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] opt_shadow = 8'h00;
    logic [1:0] mult_shadow = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Port register file model: lane k returns {port number, 0, offset}
    always_comb begin
        for (int k = 0; k < 8; k++) begin
            port_rdata[k*8 +: 8] = {4'(k + 1), 1'b0, port_addr};
        end
    end

    sio_hub dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .port_sel(port_sel), .port_wr(port_wr),
        .port_addr(port_addr), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .port_irq(port_irq),
        .irq_out(irq_out), .clk_mult(clk_mult)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_of(logic [5:0] a);
        return {4'(a[5:3] + 3'd1), 1'b0, a[2:0]};
    endfunction

    function automatic logic [7:0] opt_of(logic [7:0] w);
        return {w[7] & w[6], w[7] ^ w[6], 4'b0000, w[1:0]};
    endfunction

    // Monitor: pops the expected read result when one comes out
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rd_valid", 32'(rd_valid), 32'd0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 32'(rd_data), 32'(e));
            end
        end
    end

    task automatic do_read(logic [5:0] a, logic [7:0] e, string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        #1;
        if (a[2:0] == 3'd7) check("R3 no port enable on read", 32'(port_sel), 32'd0);
        else check("R2 read enable", 32'(port_sel), 32'(8'd1 << a[5:3]));
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_write(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        #1;
        if (a[2:0] == 3'd7) begin
            check("R3 no port enable on write", 32'(port_sel), 32'd0);
            check("R3 no port_wr", 32'(port_wr), 32'd0);
        end else begin
            check("R2 write enable", 32'(port_sel), 32'(8'd1 << a[5:3]));
            check("R2 port_wr", 32'(port_wr), 32'd1);
            check("R2 port_addr", 32'(port_addr), 32'(a[2:0]));
            check("R2 port_wdata", 32'(port_wdata), 32'(d));
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check("R11 no rd_valid after write", 32'(rd_valid), 32'd0);
    endtask

    task automatic set_irq(logic [7:0] v);
        logic prev;
        @(negedge clk);
        prev = irq_out;
        port_irq = v;
        #1;
        check("R6 irq_out not yet updated", 32'(irq_out), 32'(prev));
        @(negedge clk);
        check("R6 irq_out is OR", 32'(irq_out), 32'(|v));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 32'd0);
        check("R1 clk_mult", 32'(clk_mult), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 port_sel", 32'(port_sel), 32'd0);
        do_read(6'd7, 8'h00, "R1 offset 7 reads status after reset");

        // R5 status view through several ports
        port_irq = 8'h05;
        do_read(6'd15, 8'h05, "R5 status via port 2");
        port_irq = 8'h80;
        do_read(6'd63, 8'h80, "R5 status via port 8");
        port_irq = 8'h00;

        // R2 pass-through of offsets 0..6
        for (int p = 0; p < 8; p++) begin
            automatic logic [5:0] a = 6'(p*8 + (p % 7));
            do_read(a, lane_of(a), "R2 lane read");
        end
        do_write(6'd42, 8'h5A);

        // R4 select options through port 3, read via port 8
        do_write(6'd19, 8'h80);
        do_read(6'd63, 8'h00, "R4 options selected via another port");

        // R8 ID table with R7 reserved bits and R9 multiplier
        for (int i = 0; i < 4; i++) begin
            automatic logic [7:0] w = {2'(i), 4'b1111, 2'(3 - i)};
            do_write(6'(8*i + 7), w);
            opt_shadow = opt_of(w);
            mult_shadow = w[1:0];
            check("R9 clk_mult loaded", 32'(clk_mult), 32'(mult_shadow));
            do_read(6'(8*(7 - i) + 7), opt_shadow, "R8 ID readback / R7 reserved zero");
        end

        // R4 back to status through port 8, read via port 2
        do_write(6'd59, 8'h03);
        port_irq = 8'h3C;
        do_read(6'd15, 8'h3C, "R4 status selected via another port");
        port_irq = 8'h00;

        // R10 write to status view ignored
        do_write(6'd31, 8'hFF);
        check("R10 clk_mult unchanged", 32'(clk_mult), 32'(mult_shadow));
        port_irq = 8'h11;
        do_read(6'd7, 8'h11, "R10 selector unchanged");
        port_irq = 8'h00;
        do_write(6'd3, 8'h80);
        do_read(6'd47, opt_shadow, "R10 options unchanged");

        // R6 interrupt merge
        set_irq(8'h80);
        set_irq(8'h00);
        set_irq(8'h11);
        set_irq(8'h00);

        repeat (3) @(negedge clk);
        check("R11 all reads returned", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule